// File: doc/BRIEF.md
# Configuration Word Streamer

This block takes 32-bit configuration words from a single write port and replays them onto a parallel configuration bus together with a generated data clock. The bus is either 16 or 32 bits wide. In the narrow setting each word leaves as two halves, lower half first. A 2-bit ratio code sets how many data-clock periods each bus item is held: one, two, four or eight.

Width and ratio come from control inputs and are captured when a word is accepted. A word is taken only while the configuration enable input is high. While a word is being shifted out, `wr_ready_o` is low and the port applies backpressure. A write that arrives while the enable is low completes its handshake but is discarded.

A separate combinational helper decodes a sampled mode-select value into the width and ratio codes that the control inputs should carry. It flags any value it does not recognise, so that software can refuse to start configuration.

Top module: `cfg_stream`

## Requirements
- R1: After reset `wr_ready_o` is 1, `dclk_o` is 0 and `cfg_data_o` is 0.
- R2: A word is accepted on a clock edge where `wr_valid_i`, `wr_ready_o` and `cfg_en_i` are all 1. A handshake with `cfg_en_i` low is dropped: it causes no data-clock pulse, and `wr_ready_o` stays 1.
- R3: After an accepted word, `wr_ready_o` is 0 for exactly items x 2 x N clock cycles. Here items is 1 for the wide bus and 2 for the narrow bus, and N is the ratio in R6. Then `wr_ready_o` returns to 1.
- R4: With `width_sel_i` = 1 (32-bit bus), the whole word appears on `cfg_data_o` as one item.
- R5: With `width_sel_i` = 0 (16-bit bus), the word goes out as two items. Bits 15:0 go first, then bits 31:16. Bits 31:16 of `cfg_data_o` are 0 for both items.
- R6: `ratio_sel_i` codes 0, 1, 2 and 3 hold each item for 1, 2, 4 and 8 data-clock periods. Each period is one clock low followed by one clock high, so each item sees exactly N rising edges of `dclk_o`.
- R7: `cfg_data_o` changes only in cycles where `dclk_o` is 0, that is, on the falling edge or at the start of a word.
- R8: Width and ratio are captured at acceptance. Changing `width_sel_i` or `ratio_sel_i` while a word is in flight has no effect on that word.
- R9: Mode-select values 0, 1, 2 and 4, 5, 6 decode to width code 0 with ratio codes 0, 1, 2 respectively.
- R10: Mode-select values 8, 9, 10 and 12, 13, 14 decode to width code 1 with ratio codes 0, 2, 3 respectively.
- R11: Every other 5-bit mode-select value sets `mode_unknown_o` to 1 and drives width and ratio outputs to 0. Known values leave `mode_unknown_o` at 0.
- R12: While `wr_ready_o` is 0, data and settings presented on the write port are ignored, and the word in flight goes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration data enable; writes are dropped while low |
| width_sel_i | input | 1 | Bus width code: 0 = 16 bits, 1 = 32 bits |
| ratio_sel_i | input | 2 | Clock-to-data ratio code: 0..3 = 1, 2, 4, 8 |
| wr_valid_i | input | 1 | Write request |
| wr_data_i | input | 32 | Write word |
| wr_ready_o | output | 1 | Write port ready (low while a word is in flight) |
| dclk_o | output | 1 | Generated data clock |
| cfg_data_o | output | 32 | Configuration bus data |
| mode_sel_i | input | 5 | Sampled mode-select value |
| mode_width_o | output | 1 | Width code decoded from mode-select |
| mode_ratio_o | output | 2 | Ratio code decoded from mode-select |
| mode_unknown_o | output | 1 | Mode-select value not recognised |

## Verification
The assertions check on every cycle that:
- the bus data never moves while the data clock is high;
- the data clock alternates inside an item;
- the captured width and ratio stay put for the whole word;
- a disabled handshake leaves the port ready;
- a decoded narrow mode never carries the ratio-8 code.

Only the bench scenarios can show the rest:
- that the right items come out, in the right order and in the right number;
- that the backpressure window has the exact length;
- that values presented during backpressure are truly ignored;
- that the decode table matches over all 32 mode-select values.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic {
    BUS_NARROW = 1'b0,
    BUS_WIDE   = 1'b1
  } bus_width_e;

  localparam int unsigned KNOWN_SUB_MAX = 2;
endpackage

// File: rtl/cfg_stream_lut.sv
module cfg_stream_lut #(
  parameter int unsigned MODE_W  = 5,
  parameter int unsigned RATIO_W = 2
) (
  input  logic [MODE_W-1:0]  mode_i,
  output logic               width_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               unknown_o
);
  import cfg_stream_pkg::*;

  logic [1:0] sub;
  logic       hi_clear;
  logic       known;

  assign sub      = mode_i[1:0];
  assign hi_clear = (mode_i >> 4) == '0;
  assign known    = hi_clear && (int'(sub) <= KNOWN_SUB_MAX);

  // bit 2 selects a speed grade that does not change width or ratio
  always_comb begin
    width_o   = 1'b0;
    ratio_o   = '0;
    unknown_o = !known;
    if (known) begin
      width_o = mode_i[3];
      if (bus_width_e'(mode_i[3]) == BUS_WIDE)
        ratio_o = (sub == 2'd0) ? '0 : RATIO_W'(sub) + RATIO_W'(1);
      else
        ratio_o = RATIO_W'(sub);
    end
  end

  // R9
  always_comb narrow_ratio_chk: assert (unknown_o || width_o || ratio_o != RATIO_W'(3));
endmodule

// File: rtl/cfg_stream_pacer.sv
module cfg_stream_pacer #(
  parameter int unsigned RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               width_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               busy_o,
  output logic               wide_o,
  output logic               advance_o,
  output logic               dclk_o
);
  localparam int unsigned MAX_DIV = 1 << ((1 << RATIO_W) - 1);
  localparam int unsigned PH_W    = $clog2(2 * MAX_DIV);

  logic               busy_q, wid_q, item_q;
  logic [RATIO_W-1:0] rat_q;
  logic [PH_W-1:0]    ph_q, one_hot, ph_lim;
  logic               last_ph, last_item;

  assign one_hot   = PH_W'(1) << rat_q;
  assign ph_lim    = PH_W'((one_hot << 1) - PH_W'(1));
  assign last_ph   = ph_q == ph_lim;
  assign last_item = wid_q | item_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wid_q  <= 1'b0;
      item_q <= 1'b0;
      rat_q  <= '0;
      ph_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      wid_q  <= width_i;
      rat_q  <= ratio_i;
      item_q <= 1'b0;
      ph_q   <= '0;
    end else if (busy_q) begin
      if (last_ph) begin
        ph_q <= '0;
        if (last_item) busy_q <= 1'b0;
        else           item_q <= 1'b1;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign wide_o    = wid_q;
  assign advance_o = busy_q & last_ph & ~last_item;
  assign dclk_o    = busy_q & ph_q[0];

  // R8
  settings_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(last_ph && last_item)) |=> ($stable(rat_q) && $stable(wid_q)));

  // R6
  dclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_ph) |=> (dclk_o != $past(dclk_o)));
endmodule

// File: rtl/cfg_stream_buf.sv
module cfg_stream_buf #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              advance_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (load_i)    sh_q <= data_i;
    else if (advance_i) sh_q <= sh_q >> HALF_W;
  end

  assign data_o = wide_i ? sh_q : {{HALF_W{1'b0}}, sh_q[HALF_W-1:0]};
endmodule

// File: rtl/cfg_stream.sv
module cfg_stream #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RATIO_W = 2,
  parameter int unsigned MODE_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_en_i,
  input  logic               width_sel_i,
  input  logic [RATIO_W-1:0] ratio_sel_i,
  input  logic               wr_valid_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               wr_ready_o,
  output logic               dclk_o,
  output logic [DATA_W-1:0]  cfg_data_o,
  input  logic [MODE_W-1:0]  mode_sel_i,
  output logic               mode_width_o,
  output logic [RATIO_W-1:0] mode_ratio_o,
  output logic               mode_unknown_o
);
  logic busy, wide, advance, accept;

  assign wr_ready_o = ~busy;
  assign accept     = wr_valid_i & wr_ready_o & cfg_en_i;

  cfg_stream_pacer #(.RATIO_W(RATIO_W)) u_pacer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .width_i  (width_sel_i),
    .ratio_i  (ratio_sel_i),
    .busy_o   (busy),
    .wide_o   (wide),
    .advance_o(advance),
    .dclk_o   (dclk_o)
  );

  cfg_stream_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .data_i   (wr_data_i),
    .advance_i(advance),
    .wide_i   (wide),
    .data_o   (cfg_data_o)
  );

  cfg_stream_lut #(.MODE_W(MODE_W), .RATIO_W(RATIO_W)) u_lut (
    .mode_i   (mode_sel_i),
    .width_o  (mode_width_o),
    .ratio_o  (mode_ratio_o),
    .unknown_o(mode_unknown_o)
  );

  // R7
  data_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_data_o) |-> !dclk_o);

  // R2
  drop_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o && !cfg_en_i) |=> (wr_ready_o && !dclk_o));
endmodule

// File: tb/cfg_stream_test.sv
module cfg_stream_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, width_sel = 1'b0, wr_valid = 1'b0;
  logic [1:0]  ratio_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  mode_sel = '0;
  logic        wr_ready, dclk, mode_width, mode_unknown;
  logic [31:0] cfg_data;
  logic [1:0]  mode_ratio;

  int total = 0, bad = 0, r7_err = 0;
  logic [31:0] cap[$];
  logic        prev_dclk = 1'b0;
  logic [31:0] prev_data = '0;

  always #10 clk = ~clk;

  cfg_stream uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .width_sel_i(width_sel),
    .ratio_sel_i(ratio_sel), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .dclk_o(dclk), .cfg_data_o(cfg_data),
    .mode_sel_i(mode_sel), .mode_width_o(mode_width), .mode_ratio_o(mode_ratio),
    .mode_unknown_o(mode_unknown)
  );

  always @(negedge clk) begin
    if (dclk && !prev_dclk) cap.push_back(cfg_data);
    if (dclk && cfg_data != prev_data) r7_err++;
    prev_dclk <= dclk;
    prev_data <= cfg_data;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] item_of(input logic [31:0] d, input bit w, input int k);
    if (w) return d;
    return (k == 0) ? {16'h0, d[15:0]} : {16'h0, d[31:16]};
  endfunction

  function automatic int div_of(input logic [1:0] r);
    return 1 << r;
  endfunction

  // expected lookup: {unknown, width, ratio}
  function automatic logic [3:0] mode_exp(input logic [4:0] m);
    case (m)
      5'd0, 5'd4:   return 4'b0_0_00;
      5'd1, 5'd5:   return 4'b0_0_01;
      5'd2, 5'd6:   return 4'b0_0_10;
      5'd8, 5'd12:  return 4'b0_1_00;
      5'd9, 5'd13:  return 4'b0_1_10;
      5'd10, 5'd14: return 4'b0_1_11;
      default:      return 4'b1_0_00;
    endcase
  endfunction

  task automatic send(input logic [31:0] d, input bit w, input logic [1:0] r, input bit en);
    int busy_cnt = 0;
    int items = w ? 1 : 2;
    int n = div_of(r);
    @(negedge clk);
    cap.delete();
    r7_err = 0;
    wr_data = d; width_sel = w; ratio_sel = r; cfg_en = en; wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    while (!wr_ready) begin
      busy_cnt++;
      // R8 / R12: disturb the port while busy
      wr_data = $urandom; width_sel = 1'($urandom); ratio_sel = 2'($urandom);
      cfg_en = 1'b1;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    if (!en) begin
      chk(busy_cnt == 0, "R2 ready after dropped write", busy_cnt, 0);
      chk(cap.size() == 0, "R2 no dclk on dropped write", cap.size(), 0);
    end else begin
      chk(busy_cnt == items * 2 * n, "R3 backpressure length", busy_cnt, items * 2 * n);
      chk(cap.size() == items * n, "R6 dclk rising edges", cap.size(), items * n);
      if (cap.size() == items * n)
        for (int i = 0; i < items * n; i++)
          chk(cap[i] == item_of(d, w, i / n), w ? "R4/R12 wide item" : "R5/R12 narrow item",
              cap[i], item_of(d, w, i / n));
      chk(r7_err == 0, "R7 data stable while dclk high", r7_err, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    chk(dclk == 1'b0, "R1 dclk", dclk, 0);
    chk(cfg_data == 32'h0, "R1 data", cfg_data, 0);

    // directed corners
    send(32'hA5A5_1234, 1'b1, 2'd0, 1'b1);
    send(32'hDEAD_BEEF, 1'b0, 2'd0, 1'b1);
    send(32'h0F0F_F0F0, 1'b0, 2'd3, 1'b1);
    send(32'h1357_9BDF, 1'b1, 2'd3, 1'b1);
    send(32'hFFFF_0000, 1'b1, 2'd2, 1'b0);
    send(32'h8000_0001, 1'b0, 2'd1, 1'b1);
    for (int i = 0; i < 40; i++)
      send($urandom, 1'($urandom), 2'($urandom), ($urandom % 5) != 0);

    // R9, R10, R11: full lookup sweep
    for (int m = 0; m < 32; m++) begin
      logic [3:0] e;
      mode_sel = 5'(m);
      e = mode_exp(5'(m));
      #1;
      chk({mode_unknown, mode_width, mode_ratio} == e,
          e[3] ? "R11 unknown mode" : (e[2] ? "R10 wide mode" : "R9 narrow mode"),
          {mode_unknown, mode_width, mode_ratio}, e);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule